// File: doc/BRIEF.md
# Translation Tag Array with Address-Space-Scoped Invalidation

This block is the tag side of a small, fully associative address translation cache. Each entry holds a virtual page number, an address-space identifier, a page-level field, a valid flag and a global flag. Every cycle it compares a lookup page number and identifier against all entries at once. It returns a vector with one bit per entry and a single hit flag. The index of the matching entry selects the translation from a separate data array that sits outside this block.

New entries arrive on a write port. A round-robin pointer picks the slot they go into. A fence strobe invalidates entries. When the fence named a particular address space, the flush-all qualifier is low and entries flagged global are kept. When the fence named no address space, the qualifier is high and every entry is cleared. Both the fence and writes update state on the clock edge. Lookups are combinational on the current contents.

Top module: `xlt_tag_cam`

## Requirements
- R1: After a synchronous active-low reset no entry is valid, `hit` and `hit_vec` are zero for every lookup, and the replacement pointer is at entry 0.
- R2: Entry i hits, shown as `hit_vec[i]`=1, when it is valid, its page number matches the lookup under its level mask, and either its identifier equals `lk_asid` or its global flag is set.
- R3: An entry with level field L ignores the lowest L*SEG_W bits of the page number when it compares. Level 0 compares all VPN_W bits.
- R4: A fence with `fence_all`=1 invalidates every entry, global ones included.
- R5: A fence with `fence_all`=0 invalidates every entry whose global flag is clear, whatever its identifier, and leaves global entries valid and unchanged.
- R6: When `fence_en` and `wr_en` are high in the same cycle, the fence applies, no entry is written, and the replacement pointer does not move.
- R7: Fences and writes take effect at the next rising clock edge. A lookup in the same cycle sees the previous contents.
- R8: Each accepted write goes to the entry the pointer names, and the pointer then steps by one. After entry ENTRIES-1 it wraps to entry 0.
- R9: `hit` is 1 exactly when at least one bit of `hit_vec` is 1. Bit i of `hit_vec` belongs to entry i.
- R10: A write replaces the chosen entry whether or not it was valid, including a valid global entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| wr_en | input | 1 | Install a new entry at the replacement pointer |
| wr_vpn | input | VPN_W | Page number of the new entry |
| wr_asid | input | ASID_W | Identifier of the new entry |
| wr_global | input | 1 | Global flag of the new entry |
| wr_level | input | LVL_W | Page-level field of the new entry |
| fence_en | input | 1 | Invalidation strobe |
| fence_all | input | 1 | Also clear global entries (fence named no address space) |
| hit_vec | output | ENTRIES | Per-entry match vector |
| hit | output | 1 | Any entry matched |

## Verification
The bench uses a reduced configuration: 4 entries, 8-bit page numbers, 3-bit identifiers, two levels and a 3-bit level segment. At this size each full lookup sweep covers all 2048 page/identifier pairs against a model kept in the bench. Four entries let the bench wrap the replacement pointer with a few writes, overwrite a global entry, and mix global, non-global, level-0 and level-1 entries at once. That brings the scoped fence, the full fence, the fence-over-write priority and the level masking into reach in a few thousand cycles.

// File: rtl/xlt_cam_pkg.sv
// Package xlt_cam_pkg
// Holds the types shared by the tag array modules.
// Assumes nothing beyond IEEE 1800-2017 enums.
package xlt_cam_pkg;

    // Next-state action chosen for one tag line in a cycle
    typedef enum logic [1:0] {
        LN_HOLD = 2'd0,
        LN_LOAD = 2'd1,
        LN_DROP = 2'd2
    } ln_act_e;

endpackage

// File: rtl/xlt_victim_ptr.sv
// Module xlt_victim_ptr
// Round-robin replacement pointer. It names the slot for the next write,
// decodes that slot to a one-hot select, and steps when a write is accepted.
// Assumes ENTRIES >= 2. Reset is synchronous, active low.
module xlt_victim_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    output logic [ENTRIES-1:0] sel_vec
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Step the pointer on every accepted write, wrapping after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n)           ptr_q <= '0;
        else if (adv) begin
            if (ptr_q == LAST) ptr_q <= '0;
            else               ptr_q <= ptr_q + 1'b1;
        end
    end

    // Decode the pointer into a per-slot select
    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
        assign sel_vec[g] = (ptr_q == IDX_W'(g));
    end

    // R8
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv && ptr_q == LAST |=> ptr_q == '0);

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ptr_q));

endmodule

// File: rtl/xlt_cam_line.sv
// Module xlt_cam_line
// One tag entry: the stored page number, identifier, level, valid and
// global flags, its update rule and its lookup comparator.
// Assumes the level field stays below the number of levels the parent
// configured. A fence outranks a write to this line.
module xlt_cam_line
    import xlt_cam_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int ASID_W = 16,
    parameter int LVL_W  = 2,
    parameter int SEG_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              fence_en,
    input  logic              fence_all,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glb,
    input  logic [LVL_W-1:0]  wr_lvl,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              match
);
    logic              vld_q;
    logic              glb_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;
    logic [LVL_W-1:0]  lvl_q;
    ln_act_e           act;
    logic [VPN_W-1:0]  cmp_mask;

    // Choose the action: a fence drops non-global lines (or all on flush-all),
    // and a write loads only when no fence is active
    always_comb begin
        if (fence_en)
            act = (!glb_q || fence_all) ? LN_DROP : LN_HOLD;
        else if (sel)
            act = LN_LOAD;
        else
            act = LN_HOLD;
    end

    // Apply the chosen action to the valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else begin
            unique case (act)
                LN_LOAD: vld_q <= 1'b1;
                LN_DROP: vld_q <= 1'b0;
                default: vld_q <= vld_q;
            endcase
        end
    end

    // Capture the tag fields when the line is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q  <= 1'b0;
            vpn_q  <= '0;
            asid_q <= '0;
            lvl_q  <= '0;
        end else if (act == LN_LOAD) begin
            glb_q  <= wr_glb;
            vpn_q  <= wr_vpn;
            asid_q <= wr_asid;
            lvl_q  <= wr_lvl;
        end
    end

    // Build the compare mask: higher levels ignore more low page bits
    always_comb cmp_mask = {VPN_W{1'b1}} << (SEG_W * int'(lvl_q));

    // Compare the lookup against the stored tag
    always_comb match = vld_q
                     && (((lk_vpn ^ vpn_q) & cmp_mask) == '0)
                     && (glb_q || (asid_q == lk_asid));

    // R4
    all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_en && fence_all |=> !vld_q);

    // R5
    local_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_en && !glb_q |=> !vld_q);

    // R5
    global_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_en && !fence_all && glb_q && vld_q |=> vld_q && $stable(vpn_q) && $stable(asid_q));

    // R10
    load_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel && !fence_en |=> vld_q && vpn_q == $past(wr_vpn) && asid_q == $past(wr_asid));

endmodule

// File: rtl/xlt_hit_merge.sv
// Module xlt_hit_merge
// Folds the per-line match bits into the summary hit flag.
// Assumes at most one line matches when software keeps tags unique.
module xlt_hit_merge #(
    parameter int ENTRIES = 8
) (
    input  logic [ENTRIES-1:0] match_vec,
    output logic               hit
);
    // Reduce the match vector
    always_comb hit = |match_vec;

    // R9
    always_comb hit_vec_chk: assert (hit == (match_vec != '0));

endmodule

// File: rtl/xlt_tag_cam.sv
// Module xlt_tag_cam
// Fully associative translation tag array with scoped invalidation.
// Lookups are combinational. Writes and fences act at the next rising edge.
// Assumes the caller avoids installing duplicate tags, so hit_vec stays
// one-hot. Reset is synchronous, active low.
module xlt_tag_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 27,
    parameter int ASID_W  = 16,
    parameter int LEVELS  = 3,
    parameter int SEG_W   = 9,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic [ASID_W-1:0]  lk_asid,
    input  logic               wr_en,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0]  wr_asid,
    input  logic               wr_global,
    input  logic [LVL_W-1:0]   wr_level,
    input  logic               fence_en,
    input  logic               fence_all,
    output logic [ENTRIES-1:0] hit_vec,
    output logic               hit
);
    logic [ENTRIES-1:0] slot_sel;
    logic               wr_take;

    // A write is accepted only when no fence claims the cycle
    always_comb wr_take = wr_en && !fence_en;

    xlt_victim_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (wr_take),
        .sel_vec (slot_sel)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_line
        xlt_cam_line #(
            .VPN_W  (VPN_W),
            .ASID_W (ASID_W),
            .LVL_W  (LVL_W),
            .SEG_W  (SEG_W)
        ) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (slot_sel[i] && wr_en),
            .fence_en  (fence_en),
            .fence_all (fence_all),
            .wr_vpn    (wr_vpn),
            .wr_asid   (wr_asid),
            .wr_glb    (wr_global),
            .wr_lvl    (wr_level),
            .lk_vpn    (lk_vpn),
            .lk_asid   (lk_asid),
            .match     (hit_vec[i])
        );
    end

    xlt_hit_merge #(.ENTRIES(ENTRIES)) u_merge (
        .match_vec (hit_vec),
        .hit       (hit)
    );

    // R4
    post_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fence_en && fence_all |=> !hit);

endmodule

// File: tb/xlt_tag_cam_bench.sv
`timescale 1ns/100ps
module xlt_tag_cam_bench;
    localparam int E  = 4;
    localparam int VW = 8;
    localparam int AW = 3;
    localparam int LV = 2;
    localparam int SG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asid = '0;
    logic          wr_en = 1'b0;
    logic [VW-1:0] wr_vpn = '0;
    logic [AW-1:0] wr_asid = '0;
    logic          wr_global = 1'b0;
    logic          wr_level = 1'b0;
    logic          fence_en = 1'b0;
    logic          fence_all = 1'b0;
    logic [E-1:0]  hit_vec;
    logic          hit;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model
    logic          mvld [E];
    logic          mglb [E];
    logic [VW-1:0] mvpn [E];
    logic [AW-1:0] masid[E];
    int            mlvl [E];
    int            mptr;

    always #2.5 clk = ~clk;

    xlt_tag_cam #(.ENTRIES(E), .VPN_W(VW), .ASID_W(AW), .LEVELS(LV), .SEG_W(SG)) u_xlt_tag_cam (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_global(wr_global),
        .wr_level(wr_level), .fence_en(fence_en), .fence_all(fence_all),
        .hit_vec(hit_vec), .hit(hit)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [E-1:0] exp_vec(logic [VW-1:0] v, logic [AW-1:0] a);
        logic [E-1:0] r;
        for (int i = 0; i < E; i++) begin
            logic [VW-1:0] m;
            m = 8'hFF << (mlvl[i] * SG);
            r[i] = mvld[i] && (((v ^ mvpn[i]) & m) == '0) && (mglb[i] || masid[i] == a);
        end
        return r;
    endfunction

    task automatic sweep(string req);
        for (int v = 0; v < 256; v++) begin
            for (int a = 0; a < 8; a++) begin
                logic [E-1:0] ev;
                lk_vpn = v[VW-1:0];
                lk_asid = a[AW-1:0];
                #0.1;
                ev = exp_vec(lk_vpn, lk_asid);
                chk(req, 32'(hit_vec), 32'(ev));
                chk(req, 32'(hit), 32'(|ev));
            end
        end
    endtask

    task automatic look(string req, logic [VW-1:0] v, logic [AW-1:0] a, logic [E-1:0] exp);
        lk_vpn = v; lk_asid = a; #0.1;
        chk(req, 32'(hit_vec), 32'(exp));
    endtask

    task automatic drive(logic w, logic [VW-1:0] v, logic [AW-1:0] a, logic g, logic l,
                         logic f, logic fa);
        @(negedge clk);
        wr_en = w; wr_vpn = v; wr_asid = a; wr_global = g; wr_level = l;
        fence_en = f; fence_all = fa;
    endtask

    // update model from the driven inputs, then let the edge pass
    task automatic commit;
        if (fence_en) begin
            for (int i = 0; i < E; i++) if (!mglb[i] || fence_all) mvld[i] = 1'b0;
        end else if (wr_en) begin
            mvld[mptr] = 1'b1; mglb[mptr] = wr_global; mvpn[mptr] = wr_vpn;
            masid[mptr] = wr_asid; mlvl[mptr] = int'(wr_level);
            mptr = (mptr + 1) % E;
        end
        @(posedge clk); #0.5;
        wr_en = 1'b0; fence_en = 1'b0; fence_all = 1'b0;
    endtask

    task automatic put(logic [VW-1:0] v, logic [AW-1:0] a, logic g, logic l);
        drive(1'b1, v, a, g, l, 1'b0, 1'b0);
        commit();
    endtask

    initial begin
        for (int i = 0; i < E; i++) begin
            mvld[i] = 0; mglb[i] = 0; mvpn[i] = '0; masid[i] = '0; mlvl[i] = 0;
        end
        mptr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        sweep("R1");
        // R8: first write lands in entry 0
        put(8'h12, 3'd1, 1'b0, 1'b0);
        look("R8 R1", 8'h12, 3'd1, 4'b0001);
        put(8'h34, 3'd2, 1'b1, 1'b0);
        put(8'h50, 3'd1, 1'b0, 1'b1);
        put(8'hA7, 3'd5, 1'b1, 1'b1);
        // R3: level 1 ignores low 3 bits
        look("R3", 8'h57, 3'd1, 4'b0100);
        look("R3", 8'h58, 3'd1, 4'b0000);
        // R2: global entry hits under any identifier
        look("R2", 8'h34, 3'd7, 4'b0010);
        look("R2", 8'h12, 3'd2, 4'b0000);
        sweep("R2 R3 R9");
        // R6/R7: scoped fence with write in the same cycle
        drive(1'b1, 8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        look("R7", 8'h12, 3'd1, 4'b0001);
        commit();
        look("R5", 8'h12, 3'd1, 4'b0000);
        look("R5", 8'hA0, 3'd0, 4'b1000);
        look("R6", 8'h77, 3'd0, 4'b0000);
        sweep("R5 R6");
        // R6: pointer did not move, next write lands in entry 0
        put(8'h77, 3'd0, 1'b0, 1'b0);
        look("R6", 8'h77, 3'd0, 4'b0001);
        // R10: overwrite valid global entry 1
        put(8'h99, 3'd4, 1'b0, 1'b0);
        look("R10", 8'h34, 3'd2, 4'b0000);
        look("R10", 8'h99, 3'd4, 4'b0010);
        sweep("R10");
        // R4/R7: full fence
        drive(1'b0, 8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1);
        look("R7", 8'hA1, 3'd5, 4'b1000);
        commit();
        look("R4", 8'hA1, 3'd5, 4'b0000);
        sweep("R4");
        // R8: wrap; pointer at 2, five writes go 2,3,0,1,2
        for (int k = 0; k < 5; k++) put(8'h10 + 8'(k), 3'(k), 1'b0, 1'b0);
        look("R8", 8'h14, 3'd4, 4'b0100);
        look("R8", 8'h11, 3'd1, 4'b1000);
        look("R8", 8'h10, 3'd0, 4'b0000);
        sweep("R8 R9");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule